// File: doc/BRIEF.md
# Dual-Clause MDIO Management Controller

This block is a register-driven management-bus master. A processor uses it to read and write PHY registers over the two-wire MDC/MDIO bus. A small register file holds the configuration and the operands. A write to the right register starts a bus frame. Each frame is 64 MDC periods long and uses either the clause-22 or the clause-45 framing.

MDC is derived from the system clock by a programmable divider. MDIO leaves the block as a data bit plus an output enable, so that a pad tristate can be built around it. MDIO comes back in on its own input. In clause-45 mode the register address is sent in its own address frame before the data operation. The status register and the data register each have their own busy flag. A read whose turnaround bit is not pulled to zero by the PHY raises a read-error flag, and software then reads the result as all ones.

Top module: `mdio_master`

## Requirements
- R1: After reset the configuration register (index 0) reads 0x8 with the default divider of zero: clause-22, not busy, no read error, polarity bit 1. The data busy flag (index 3, bit 31) reads 0, MDC is low and the output enable is low.
- R2: Register index 0 holds the clause-45 select in bit 0, busy in bit 1 (read-only), read error in bit 2 (read-only), the MDC polarity bit in bit 3 and the divider in bits 16 and up. The divider field holds at least 258. Index 1 holds the PHY address in [4:0] and the device/register number in [9:5]; writing 1 to its bit 15 starts a read, and bit 15 reads back as 0. Index 2 holds a 16-bit register address. Index 3 holds 16 data bits, with the data busy flag in bit 31.
- R3: In clause-22 mode a write to index 3 sends 32 ones, then start 01, opcode 01, the PHY address, the register number from [9:5] of index 1, turnaround 10 and the 16 data bits, most significant bit first.
- R4: In clause-22 mode a read sends start 01 and opcode 10. When the frame ends, index 3 [15:0] holds the 16 bits sampled from the PHY, first bit sampled in bit 15.
- R5: In clause-45 mode a write to index 2 sends an address frame with start 00 and opcode 00, carrying the 16-bit address. The status busy flag is set during this frame and the data busy flag stays clear.
- R6: In clause-45 mode a data write uses start 00 and opcode 01, and a read uses start 00 and opcode 11.
- R7: The read-error flag is set when the PHY leaves the second turnaround bit of a read at 1. The flag is cleared when the next read starts.
- R8: Every frame keeps busy set for exactly 128*(divider+1) system clocks, counted from the register write. Write and read frames also keep the data busy flag set for that time.
- R9: During a frame MDC toggles every divider+1 system clocks. MDIO changes only while MDC is low. MDC idles low.
- R10: With a divider of zero MDC does not toggle and a started frame does not advance. Writing a nonzero divider lets the frame complete.
- R11: With the polarity bit at 0 the MDC output is inverted, so it idles high.
- R12: While busy, writes to index 1, 2 and 3 are ignored. In clause-22 mode a write to index 2 stores the address but starts no frame.
- R13: During a read the output enable is low for both turnaround bits and all 16 data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input |

## Verification
A wrong bit counter or shift register shows within one frame as a wrong captured bit on MDIO. A counter that is off by one makes busy clear one or more system clocks early or late, against the exact 128*(divider+1) count. A wrong divider count shows at the second MDC edge of a frame as a half period of the wrong length. Faults in read capture or in the turnaround check show when the frame ends, as a wrong data word or a wrong read-error bit. A missing write guard leaves the data or control register changed when it is read back after the frame.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W = 10,
  parameter logic [DIV_W-1:0] DIV_RESET = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_BITS = 64;
  localparam int CW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] TA_BIT = CW'(46);
  localparam logic [CW-1:0] DATA_BIT = CW'(48);

  logic             c45_q, neg_q, err_q;
  logic [DIV_W-1:0] div_q, cnt_q;
  logic [4:0]       port_q, dev_q;
  logic [15:0]      radr_q, data_q, cap_q;
  logic             active, rd_q, adr_q, mdc_r;
  logic [CW-1:0]    bit_q;
  logic [63:0]      sh_q;

  logic tick, last, idle_wr;
  logic unused_bits;
  assign unused_bits = ^reg_wdata[31:16+DIV_W];

  assign tick    = active && (div_q != '0) && (cnt_q == div_q);
  assign last    = tick && mdc_r && (bit_q == LAST_BIT);
  assign idle_wr = reg_we && !active;

  function automatic logic [63:0] frame(input logic [1:0] st, input logic [1:0] op,
                                        input logic [4:0] pa, input logic [4:0] da,
                                        input logic [15:0] dat);
    return {32'hFFFF_FFFF, st, op, pa, da, 2'b10, dat};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c45_q <= 1'b0; neg_q <= 1'b1; err_q <= 1'b0; div_q <= DIV_RESET;
      cnt_q <= '0; port_q <= '0; dev_q <= '0; radr_q <= '0; data_q <= '0;
      cap_q <= '0; active <= 1'b0; rd_q <= 1'b0; adr_q <= 1'b0; mdc_r <= 1'b0;
      bit_q <= '0; sh_q <= '0;
    end else begin
      if (reg_we && reg_addr == 2'd0) begin
        c45_q <= reg_wdata[0];
        neg_q <= reg_wdata[3];
        div_q <= reg_wdata[16 +: DIV_W];
      end

      if (active && div_q != '0)
        cnt_q <= tick ? '0 : cnt_q + 1'b1;

      if (tick) begin
        if (!mdc_r) begin
          mdc_r <= 1'b1;
          if (rd_q && bit_q == TA_BIT + 1'b1) err_q <= mdio_i;
          if (rd_q && bit_q >= DATA_BIT) cap_q <= {cap_q[14:0], mdio_i};
        end else begin
          mdc_r <= 1'b0;
          if (last) begin
            active <= 1'b0;
            if (rd_q) data_q <= cap_q;
          end else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[62:0], 1'b1};
          end
        end
      end

      if (idle_wr) begin
        case (reg_addr)
          2'd1: begin
            port_q <= reg_wdata[4:0];
            dev_q  <= reg_wdata[9:5];
            if (reg_wdata[15]) begin
              active <= 1'b1; rd_q <= 1'b1; adr_q <= 1'b0; err_q <= 1'b0;
              bit_q <= '0; cnt_q <= '0; mdc_r <= 1'b0;
              sh_q <= frame(c45_q ? 2'b00 : 2'b01, c45_q ? 2'b11 : 2'b10,
                            reg_wdata[4:0], reg_wdata[9:5], 16'hFFFF);
            end
          end
          2'd2: begin
            radr_q <= reg_wdata[15:0];
            if (c45_q) begin
              active <= 1'b1; rd_q <= 1'b0; adr_q <= 1'b1;
              bit_q <= '0; cnt_q <= '0; mdc_r <= 1'b0;
              sh_q <= frame(2'b00, 2'b00, port_q, dev_q, reg_wdata[15:0]);
            end
          end
          2'd3: begin
            data_q <= reg_wdata[15:0];
            active <= 1'b1; rd_q <= 1'b0; adr_q <= 1'b0;
            bit_q <= '0; cnt_q <= '0; mdc_r <= 1'b0;
            sh_q <= frame(c45_q ? 2'b00 : 2'b01, 2'b01, port_q, dev_q, reg_wdata[15:0]);
          end
          default: ;
        endcase
      end
    end
  end

  assign mdc     = mdc_r ^ ~neg_q;
  assign mdio_o  = sh_q[63];
  assign mdio_oe = active && !(rd_q && bit_q >= TA_BIT);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: begin
        reg_rdata[0] = c45_q;
        reg_rdata[1] = active;
        reg_rdata[2] = err_q;
        reg_rdata[3] = neg_q;
        reg_rdata[16 +: DIV_W] = div_q;
      end
      2'd1: reg_rdata[9:0] = {dev_q, port_q};
      2'd2: reg_rdata[15:0] = radr_q;
      default: begin
        reg_rdata[15:0] = data_q;
        reg_rdata[31] = active && !adr_q;
      end
    endcase
  end

  assert_mdio_still_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc_r) |-> $stable(mdio_o));
  assert_mdc_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mdc_r);
  assert_frame_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(bit_q) == LAST_BIT);
  assert_div_zero_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |=> $stable(mdc_r));
  assert_data_guard_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last && reg_we && reg_addr == 2'd3) |=> $stable(data_q));
  assert_error_only_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(rd_q));
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i;
  logic phy_en = 1'b0, phy_v = 1'b1, phy_rd = 1'b0, phy_ta_bad = 1'b0;
  logic [15:0] phy_data = '0;
  logic [63:0] cap = '0;
  int ncap = 0, oe_viol = 0, per_err = 0, gap = 0, cur_div = 0;
  bit have_edge = 0;
  logic prev_mdc = 1'b0;
  int checks = 0, errors = 0;

  mdio_master u_dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_v : 1'b1);

  // PHY model: capture on rising MDC, drive on falling MDC
  always @(posedge mdc) begin
    if (phy_rd && ncap >= 46 && mdio_oe) oe_viol++;
    cap = {cap[62:0], mdio_i};
    ncap++;
  end
  always @(negedge mdc) begin
    if (phy_rd && ncap >= 46 && ncap < 64) begin
      phy_en = 1'b1;
      phy_v = (ncap == 46) ? 1'b1 : (ncap == 47) ? phy_ta_bad : phy_data[63-ncap];
    end else phy_en = 1'b0;
  end

  // MDC half-period monitor, every clock
  always @(negedge clk) begin
    if (mdc !== prev_mdc) begin
      if (have_edge && gap != cur_div + 1) per_err++;
      have_edge = 1;
      gap = 1;
    end else gap++;
    prev_mdc = mdc;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic arm(input bit rd);
    ncap = 0; oe_viol = 0; per_err = 0; have_edge = 0; phy_rd = rd;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] s;
    n = 0;
    reg_read(2'd0, s);
    while (s[1] && n < 100000) begin
      n++;
      @(negedge clk);
      reg_read(2'd0, s);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic [1:0] st, input logic [1:0] op,
      input logic [4:0] pa, input logic [4:0] da, input logic [15:0] dat);
    return {32'hFFFF_FFFF, st, op, pa, da, 2'b10, dat};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(2'd0, r); check(r == 32'h8, "R1 cfg", r, 32'h8);
    reg_read(2'd3, r); check(r[31] == 1'b0, "R1 data busy", r[31], 0);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins", {mdc, mdio_oe}, 0);

    // R2 divider range and control readback
    reg_write(2'd0, (32'd258 << 16) | 32'h8);
    reg_read(2'd0, r); check(r[25:16] == 10'd258, "R2 divider 258", r[25:16], 258);
    reg_write(2'd1, 32'h0000_0145);
    reg_read(2'd1, r); check(r == 32'h145, "R2 ctrl readback", r, 32'h145);

    // R3/R8/R9 clause-22 write
    cur_div = 2;
    reg_write(2'd0, (32'd2 << 16) | 32'h8);
    arm(0);
    reg_write(2'd3, 32'h0000_BEEF);
    reg_read(2'd3, r); check(r[31] == 1'b1, "R8 data busy set", r[31], 1);
    wait_idle(n);
    check(n == 128 * 3, "R8 frame length", n, 128 * 3);
    check(ncap == 64 && cap == exp_frame(2'b01, 2'b01, 5'd5, 5'd10, 16'hBEEF),
          "R3 c22 write frame", cap, exp_frame(2'b01, 2'b01, 5'd5, 5'd10, 16'hBEEF));
    check(per_err == 0, "R9 mdc half period", per_err, 0);
    check(mdc == 1'b0, "R9 mdc idle low", mdc, 0);

    // R4/R13 clause-22 read
    phy_data = 16'h1234; phy_ta_bad = 0;
    arm(1);
    reg_write(2'd1, 32'h0000_8145);
    wait_idle(n);
    check(cap[63:18] == exp_frame(2'b01, 2'b10, 5'd5, 5'd10, 16'h0)[63:18],
          "R4 c22 read header", cap[63:18], exp_frame(2'b01, 2'b10, 5'd5, 5'd10, 16'h0)[63:18]);
    reg_read(2'd3, r); check(r == 32'h1234, "R4 read data", r, 32'h1234);
    reg_read(2'd0, r); check(r[2] == 1'b0, "R7 no read error", r[2], 0);
    check(oe_viol == 0, "R13 released during read", oe_viol, 0);
    reg_read(2'd1, r); check(r[15] == 1'b0, "R2 read bit reads 0", r[15], 0);

    // R5 clause-45 address frame
    reg_write(2'd0, (32'd2 << 16) | 32'h9);
    reg_write(2'd1, 32'h0000_0023);
    arm(0);
    reg_write(2'd2, 32'h0000_A55A);
    reg_read(2'd0, r); check(r[1] == 1'b1, "R5 status busy", r[1], 1);
    reg_read(2'd3, r); check(r[31] == 1'b0, "R5 data busy clear", r[31], 0);
    wait_idle(n);
    check(n == 128 * 3, "R8 address frame length", n, 128 * 3);
    check(cap == exp_frame(2'b00, 2'b00, 5'd3, 5'd1, 16'hA55A),
          "R5 c45 address frame", cap, exp_frame(2'b00, 2'b00, 5'd3, 5'd1, 16'hA55A));

    // R6 clause-45 write and read
    arm(0);
    reg_write(2'd3, 32'h0000_0F0F);
    wait_idle(n);
    check(cap == exp_frame(2'b00, 2'b01, 5'd3, 5'd1, 16'h0F0F),
          "R6 c45 write frame", cap, exp_frame(2'b00, 2'b01, 5'd3, 5'd1, 16'h0F0F));
    phy_data = 16'hCAFE;
    arm(1);
    reg_write(2'd1, 32'h0000_8023);
    wait_idle(n);
    check(cap[63:18] == exp_frame(2'b00, 2'b11, 5'd3, 5'd1, 16'h0)[63:18],
          "R6 c45 read header", cap[63:18], exp_frame(2'b00, 2'b11, 5'd3, 5'd1, 16'h0)[63:18]);
    reg_read(2'd3, r); check(r == 32'hCAFE, "R6 c45 read data", r, 32'hCAFE);
    check(oe_viol == 0 && per_err == 0, "R13 c45 read release", {oe_viol, per_err}, 0);

    // R7 read error, then cleared by next read
    phy_ta_bad = 1;
    arm(1);
    reg_write(2'd1, 32'h0000_8023);
    wait_idle(n);
    reg_read(2'd0, r); check(r[2] == 1'b1, "R7 read error set", r[2], 1);
    phy_ta_bad = 0;
    arm(1);
    reg_write(2'd1, 32'h0000_8023);
    wait_idle(n);
    reg_read(2'd0, r); check(r[2] == 1'b0, "R7 read error cleared", r[2], 0);
    phy_rd = 0;

    // R12 writes ignored while busy
    reg_write(2'd0, (32'd2 << 16) | 32'h8);
    reg_write(2'd1, 32'h0000_0145);
    arm(0);
    reg_write(2'd3, 32'h0000_1111);
    repeat (20) @(negedge clk);
    reg_write(2'd3, 32'h0000_2222);
    reg_write(2'd1, 32'h0000_83FF);
    reg_write(2'd0, (32'd2 << 16) | 32'h8);
    reg_write(2'd2, 32'h0000_7777);
    wait_idle(n);
    reg_read(2'd3, r); check(r == 32'h1111, "R12 data kept", r, 32'h1111);
    reg_read(2'd1, r); check(r == 32'h145, "R12 ctrl kept", r, 32'h145);
    reg_read(2'd2, r); check(r == 32'hA55A, "R12 address kept", r, 32'hA55A);
    check(cap == exp_frame(2'b01, 2'b01, 5'd5, 5'd10, 16'h1111),
          "R12 frame unchanged", cap, exp_frame(2'b01, 2'b01, 5'd5, 5'd10, 16'h1111));

    // R12 clause-22 address write starts nothing
    reg_write(2'd2, 32'h0000_4242);
    reg_read(2'd0, r); check(r[1] == 1'b0, "R12 c22 address no frame", r[1], 0);
    reg_read(2'd2, r); check(r == 32'h4242, "R12 c22 address stored", r, 32'h4242);

    // R10 divider zero halts, then resumes
    reg_write(2'd0, 32'h8);
    arm(0);
    reg_write(2'd3, 32'h0000_3C3C);
    repeat (300) @(negedge clk);
    check(!have_edge && mdc == 1'b0, "R10 mdc frozen", have_edge, 0);
    reg_read(2'd0, r); check(r[1] == 1'b1, "R10 still busy", r[1], 1);
    reg_write(2'd0, (32'd2 << 16) | 32'h8);
    wait_idle(n);
    check(n == 128 * 3, "R10 resume length", n, 128 * 3);
    check(cap == exp_frame(2'b01, 2'b01, 5'd5, 5'd10, 16'h3C3C),
          "R10 frame after resume", cap, exp_frame(2'b01, 2'b01, 5'd5, 5'd10, 16'h3C3C));

    // R11 polarity
    reg_write(2'd0, 32'd2 << 16);
    @(negedge clk);
    check(mdc == 1'b1, "R11 inverted idle high", mdc, 1);
    reg_write(2'd0, (32'd2 << 16) | 32'h8);
    @(negedge clk);
    check(mdc == 1'b0, "R11 normal idle low", mdc, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule